// File: doc/BRIEF.md
# PIO Configuration Request Engine

This block lets software issue one configuration read or write at a time toward a PCIe-style link without building packets itself. Software fills in a small bank of registers over a plain write-and-read register bus: the request type, a 64-bit target address split in two words, the write data and a byte-enable mask. It clears the done flag and then sets the start bit. The engine snapshots those fields, presents them for one cycle on a request port, and waits for a single response from the link side.

When the response arrives, the engine records its completion code and error flag, captures read data when the read succeeded, drops the busy bit and raises the done flag in the same cycle. If the link never answers, an internal counter ends the transfer after a fixed number of cycles and reports a completer abort with the error flag set. Software polls until start reads 0 and done reads 1, then inspects the status word.

Top module: `pio_cfg_engine`

## Requirements
- R1: After reset every register reads 0, the request port is idle and start reads 0.
- R2: Byte offsets: control 0x00, status 0x04, address low 0x08, address high 0x0C, write data 0x10, byte mask 0x14, read data 0x18, start 0x1C, done flag 0x20. Control keeps only the type field in bits [3:0] and the window-bypass flag in bit 24, with all other control bits reading 0. The address words and write data read back as written, and the byte mask keeps bits [3:0].
- R3: Writing 1 to bit 0 of start while idle produces exactly one request cycle, on the clock after the write, carrying the type, the address as {high word, low word} and the write data; start then reads 1 until the transfer finishes.
- R4: Request type codes are 0x8 type-0 read, 0x9 type-1 read, 0xA type-0 write, 0xB type-1 write. For the two read codes the request drives mask 0xF; for any other code it drives the programmed mask.
- R5: A write to start while a transfer is in flight has no effect: no further request cycle is produced and the running transfer ends normally on its response.
- R6: A response ends the transfer: in that same clock start clears and done bit 0 sets. Status bits [9:7] take the response code (0 success, 1 unsupported, 2 retry-later, 4 completer abort, other values unknown), bit 11 takes the response error flag, and bit 10 is set when type bit 3 is set (a non-posted configuration request).
- R7: The read-data register loads the response data only for a read code with code 0 and error flag clear; in all other completions it keeps its previous value.
- R8: If no response arrives within TIMEOUT_CYCLES clocks after the start is accepted, the transfer ends with code 4 and the error flag set, start clears and done sets.
- R9: Writing 1 to done bit 0 clears it and writing 0 leaves it; a completion in the same clock as a clearing write leaves done set.
- R10: A response that arrives while no transfer is in flight changes no register.
- R11: Writes to the status and read-data offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| req_valid | output | 1 | One-cycle request strobe |
| req_type | output | 4 | Request type code |
| req_addr | output | 64 | Request target address |
| req_wdata | output | 32 | Request write data |
| req_strb | output | 4 | Request byte mask |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_status | input | 3 | Response completion code |
| rsp_err | input | 1 | Response error flag |
| rsp_data | input | 32 | Response read data |

## Verification
The in-line properties watch, every cycle, that a request strobe lasts one cycle and only follows an accepted start, that no request is issued while a transfer runs, that every completion leaves start clear and done set, that a silent link ends in a code-4 error completion, and that read data holds on any completion that does not qualify. What the properties cannot show is the value mapping: the status bit positions, the non-posted flag per type, the forced read mask, the control-register masking, the exact timeout length and the done-flag priority against a same-cycle clear. The bench shows these by sweeping every type code against every completion code and error flag and comparing readback with arithmetic expectations.

// File: rtl/pio_cfg_pkg.sv
package pio_cfg_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 6;

    localparam logic [OFF_W-1:0] OFF_CTRL   = 6'h00;
    localparam logic [OFF_W-1:0] OFF_STATUS = 6'h04;
    localparam logic [OFF_W-1:0] OFF_ADDR_L = 6'h08;
    localparam logic [OFF_W-1:0] OFF_ADDR_H = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_WDATA  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_STRB   = 6'h14;
    localparam logic [OFF_W-1:0] OFF_RDATA  = 6'h18;
    localparam logic [OFF_W-1:0] OFF_START  = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_DONE   = 6'h20;

    localparam logic [3:0] TYPE_RD0 = 4'h8;
    localparam logic [3:0] TYPE_RD1 = 4'h9;

    localparam logic [2:0] CODE_OK    = 3'd0;
    localparam logic [2:0] CODE_ABORT = 3'd4;

    typedef struct packed {
        logic [2:0]        code;
        logic              err;
        logic              nonposted;
        logic              is_read;
        logic [DATA_W-1:0] data;
    } cpl_t;

    function automatic logic type_is_read(input logic [3:0] t);
        return (t == TYPE_RD0) || (t == TYPE_RD1);
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [OFF_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 busy,
    input  logic                 cpl_valid,
    input  cpl_t                 cpl,
    output logic                 start_wr,
    output logic [3:0]           cfg_type,
    output logic [2*DATA_W-1:0]  cfg_addr,
    output logic [DATA_W-1:0]    cfg_wdata,
    output logic [3:0]           cfg_strb,
    output logic                 done
);

    typedef struct packed {
        logic [3:0]        rtype;
        logic              win_bypass;
        logic [DATA_W-1:0] addr_lo;
        logic [DATA_W-1:0] addr_hi;
        logic [DATA_W-1:0] wdata;
        logic [3:0]        strb;
        logic [2:0]        code;
        logic              err;
        logic              nonposted;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (bus_addr)
                OFF_CTRL: begin
                    regs_d.rtype      = bus_wdata[3:0];
                    regs_d.win_bypass = bus_wdata[24];
                end
                OFF_ADDR_L: regs_d.addr_lo = bus_wdata;
                OFF_ADDR_H: regs_d.addr_hi = bus_wdata;
                OFF_WDATA:  regs_d.wdata   = bus_wdata;
                OFF_STRB:   regs_d.strb    = bus_wdata[3:0];
                OFF_DONE:   if (bus_wdata[0]) regs_d.done = 1'b0;
                default: ;
            endcase
        end
        if (cpl_valid) begin
            regs_d.code      = cpl.code;
            regs_d.err       = cpl.err;
            regs_d.nonposted = cpl.nonposted;
            regs_d.done      = 1'b1;
            if (cpl.is_read && (cpl.code == CODE_OK) && !cpl.err)
                regs_d.rdata = cpl.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            OFF_CTRL:   bus_rdata = {7'b0, regs_q.win_bypass, 20'b0, regs_q.rtype};
            OFF_STATUS: bus_rdata = {20'b0, regs_q.err, regs_q.nonposted, regs_q.code, 7'b0};
            OFF_ADDR_L: bus_rdata = regs_q.addr_lo;
            OFF_ADDR_H: bus_rdata = regs_q.addr_hi;
            OFF_WDATA:  bus_rdata = regs_q.wdata;
            OFF_STRB:   bus_rdata = {28'b0, regs_q.strb};
            OFF_RDATA:  bus_rdata = regs_q.rdata;
            OFF_START:  bus_rdata = {31'b0, busy};
            OFF_DONE:   bus_rdata = {31'b0, regs_q.done};
            default:    bus_rdata = '0;
        endcase
    end

    assign start_wr  = bus_we && (bus_addr == OFF_START) && bus_wdata[0];
    assign cfg_type  = regs_q.rtype;
    assign cfg_addr  = {regs_q.addr_hi, regs_q.addr_lo};
    assign cfg_wdata = regs_q.wdata;
    assign cfg_strb  = regs_q.strb;
    assign done      = regs_q.done;

    // R7: a completion that does not qualify leaves read data untouched
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !(cpl.is_read && cpl.code == CODE_OK && !cpl.err))
        |=> $stable(regs_q.rdata));

    // R10: with no transfer running, a response leaves the status word alone
    p_idle_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(bus_we && bus_addr == OFF_START)) |=>
        ($stable(regs_q.code) && $stable(regs_q.err)));

endmodule

// File: rtl/pio_cfg_seq.sv
module pio_cfg_seq
    import pio_cfg_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_wr,
    input  logic [3:0]           cfg_type,
    input  logic [2*DATA_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [3:0]           cfg_strb,
    input  logic                 rsp_valid,
    input  logic [2:0]           rsp_status,
    input  logic                 rsp_err,
    input  logic [DATA_W-1:0]    rsp_data,
    output logic                 req_valid,
    output logic [3:0]           req_type,
    output logic [2*DATA_W-1:0]  req_addr,
    output logic [DATA_W-1:0]    req_wdata,
    output logic [3:0]           req_strb,
    output logic                 busy,
    output logic                 cpl_valid,
    output cpl_t                 cpl
);

    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    typedef enum logic { S_IDLE, S_WAIT } state_e;

    typedef struct packed {
        state_e               state;
        logic                 req;
        logic [3:0]           rtype;
        logic [2*DATA_W-1:0]  addr;
        logic [DATA_W-1:0]    wdata;
        logic [3:0]           strb;
        logic [CNT_W-1:0]     cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.req = 1'b0;
        cpl_valid = 1'b0;
        cpl       = '0;
        case (seq_q.state)
            S_IDLE: begin
                if (start_wr) begin
                    seq_d.state = S_WAIT;
                    seq_d.req   = 1'b1;
                    seq_d.rtype = cfg_type;
                    seq_d.addr  = cfg_addr;
                    seq_d.wdata = cfg_wdata;
                    seq_d.strb  = type_is_read(cfg_type) ? 4'hF : cfg_strb;
                    seq_d.cnt   = '0;
                end
            end
            default: begin
                cpl.nonposted = seq_q.rtype[3];
                cpl.is_read   = type_is_read(seq_q.rtype);
                if (rsp_valid) begin
                    cpl_valid   = 1'b1;
                    cpl.code    = rsp_status;
                    cpl.err     = rsp_err;
                    cpl.data    = rsp_data;
                    seq_d.state = S_IDLE;
                end else if (seq_q.cnt == CNT_LAST) begin
                    cpl_valid   = 1'b1;
                    cpl.code    = CODE_ABORT;
                    cpl.err     = 1'b1;
                    seq_d.state = S_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: S_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.state == S_WAIT);
    assign req_valid = seq_q.req;
    assign req_type  = seq_q.rtype;
    assign req_addr  = seq_q.addr;
    assign req_wdata = seq_q.wdata;
    assign req_strb  = seq_q.strb;

    // R3: the request strobe is a single cycle
    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R3: a request only follows a start written while idle
    p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(start_wr && !busy));

    // R5: no new request while the previous transfer is still running
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !req_valid);

    // R4: read codes always carry the full byte mask
    p_read_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && type_is_read(req_type)) |-> (req_strb == 4'hF));

endmodule

// File: rtl/pio_cfg_engine.sv
module pio_cfg_engine
    import pio_cfg_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [5:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic         req_valid,
    output logic [3:0]   req_type,
    output logic [63:0]  req_addr,
    output logic [31:0]  req_wdata,
    output logic [3:0]   req_strb,
    input  logic         rsp_valid,
    input  logic [2:0]   rsp_status,
    input  logic         rsp_err,
    input  logic [31:0]  rsp_data
);

    logic                start_wr;
    logic                busy;
    logic                cpl_valid;
    cpl_t                cpl;
    logic [3:0]          cfg_type;
    logic [2*DATA_W-1:0] cfg_addr;
    logic [DATA_W-1:0]   cfg_wdata;
    logic [3:0]          cfg_strb;
    logic                done;

    pio_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .cpl_valid (cpl_valid),
        .cpl       (cpl),
        .start_wr  (start_wr),
        .cfg_type  (cfg_type),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_strb  (cfg_strb),
        .done      (done)
    );

    pio_cfg_seq #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .cfg_type   (cfg_type),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_strb   (cfg_strb),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_err    (rsp_err),
        .rsp_data   (rsp_data),
        .req_valid  (req_valid),
        .req_type   (req_type),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_strb   (req_strb),
        .busy       (busy),
        .cpl_valid  (cpl_valid),
        .cpl        (cpl)
    );

    // R6: every completion leaves start clear and done set
    p_cpl_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> (!busy && done));

    // R8: a silent link ends in an abort with the error flag set
    p_timeout_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !rsp_valid) |-> (cpl.code == CODE_ABORT && cpl.err));

endmodule

// File: tb/pio_cfg_engine_tb_top.sv
`timescale 1ns/1ps
module pio_cfg_engine_tb_top;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic [3:0]  req_type;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_status = '0;
    logic        rsp_err = 1'b0;
    logic [31:0] rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_rdata = '0;

    always #4 clk = ~clk;

    pio_cfg_engine #(.TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_strb(req_strb), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic respond(input logic [2:0] c, input logic e, input logic [31:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_status = c; rsp_err = e; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // one full transfer with a response after some idle cycles
    task automatic txn(input logic [3:0] t, input logic [2:0] c, input logic e,
                       input logic [3:0] sb, input int dly, input int idx);
        logic [31:0] v;
        logic [31:0] ad_lo, ad_hi, wd, rdv;
        logic        is_rd;
        ad_lo = 32'h0010_0000 + idx * 32'h104;
        ad_hi = 32'hA500_0000 ^ idx;
        wd    = 32'hC0DE_0000 + idx;
        rdv   = 32'h5EED_0000 + idx * 32'h11;
        is_rd = (t == 4'h8) || (t == 4'h9);
        wr(6'h00, {7'b0, 1'b1, 20'b0, t});
        wr(6'h08, ad_lo);
        wr(6'h0C, ad_hi);
        wr(6'h10, wd);
        wr(6'h14, {28'b0, sb});
        wr(6'h20, 32'h1);
        wr(6'h1C, 32'h1);
        // R3: request strobe present in the cycle after the start write
        chk("R3 req_valid", req_valid, 1);
        chk("R3 req_type", req_type, t);
        chk("R3 req_addr", req_addr, {ad_hi, ad_lo});
        chk("R3 req_wdata", req_wdata, wd);
        chk("R4 req_strb", req_strb, is_rd ? 4'hF : sb);
        rd(6'h1C, v);
        chk("R3 start busy", v, 1);
        repeat (dly) @(negedge clk);
        chk("R3 req one cycle", req_valid, 0);
        respond(c, e, rdv);
        rd(6'h1C, v);
        chk("R6 start cleared", v, 0);
        rd(6'h20, v);
        chk("R6 done set", v, 1);
        rd(6'h04, v);
        chk("R6 status word", v, {20'b0, e, t[3], c, 7'b0});
        if (is_rd && c == 3'd0 && !e) exp_rdata = rdv;
        rd(6'h18, v);
        chk("R7 read data", v, exp_rdata);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a <= 8; a++) begin
            rd(6'(a * 4), v);
            chk("R1 reset readback", v, 0);
        end
        chk("R1 req idle", req_valid, 0);

        // R2: register storage and masking
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v); chk("R2 ctrl mask", v, 32'h0100_000F);
        wr(6'h00, 32'h0000_0003);
        rd(6'h00, v); chk("R2 ctrl no bypass", v, 32'h0000_0003);
        wr(6'h08, 32'h1234_5678); rd(6'h08, v); chk("R2 addr low", v, 32'h1234_5678);
        wr(6'h0C, 32'h9ABC_DEF0); rd(6'h0C, v); chk("R2 addr high", v, 32'h9ABC_DEF0);
        wr(6'h10, 32'hDEAD_BEEF); rd(6'h10, v); chk("R2 wdata", v, 32'hDEAD_BEEF);
        wr(6'h14, 32'hFFFF_FFF6); rd(6'h14, v); chk("R2 strb", v, 32'h6);

        // R11: read-only offsets
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R11 status ro", v, 0);
        wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, v); chk("R11 rdata ro", v, 0);

        // sweep types x codes x error flag (R3, R4, R6, R7)
        idx = 0;
        for (int ti = 0; ti < 4; ti++) begin
            for (int ci = 0; ci < 8; ci++) begin
                for (int ei = 0; ei < 2; ei++) begin
                    txn(4'(8 + ti), 3'(ci), 1'(ei), 4'(idx), 1 + (idx % 3), idx);
                    idx++;
                end
            end
        end
        // non-config code carries the programmed mask and is not non-posted
        txn(4'h2, 3'd0, 1'b0, 4'hC, 2, idx);

        // R5: second start while busy is ignored
        wr(6'h00, 32'h8);
        wr(6'h20, 32'h1);
        wr(6'h1C, 32'h1);
        chk("R5 first req", req_valid, 1);
        wr(6'h1C, 32'h1);
        chk("R5 no second req", req_valid, 0);
        @(negedge clk);
        chk("R5 no later req", req_valid, 0);
        rd(6'h1C, v); chk("R5 still busy", v, 1);
        respond(3'd0, 1'b0, 32'hFACE_0001);
        exp_rdata = 32'hFACE_0001;
        rd(6'h1C, v); chk("R5 ends on response", v, 0);
        rd(6'h18, v); chk("R5 data from response", v, exp_rdata);
        @(negedge clk);
        chk("R5 no trailing req", req_valid, 0);

        // R10: response while idle changes nothing
        wr(6'h20, 32'h1);
        respond(3'd1, 1'b1, 32'h0BAD_0BAD);
        rd(6'h04, v); chk("R10 status kept", v, {20'b0, 1'b0, 1'b1, 3'd0, 7'b0});
        rd(6'h20, v); chk("R10 done kept", v, 0);
        rd(6'h18, v); chk("R10 rdata kept", v, exp_rdata);

        // R8: timeout length and result
        wr(6'h00, 32'h9);
        wr(6'h20, 32'h1);
        wr(6'h1C, 32'h1);
        n = 0;
        rd(6'h1C, v);
        while (v == 32'h1 && n < 10 * TMO) begin
            @(negedge clk);
            n++;
            rd(6'h1C, v);
        end
        chk("R8 timeout cycles", n, TMO);
        rd(6'h04, v); chk("R8 abort status", v, {20'b0, 1'b1, 1'b1, 3'd4, 7'b0});
        rd(6'h20, v); chk("R8 done set", v, 1);
        rd(6'h18, v); chk("R8 rdata kept", v, exp_rdata);

        // R9: done flag write-1-to-clear
        wr(6'h20, 32'h0); rd(6'h20, v); chk("R9 write 0 keeps", v, 1);
        wr(6'h20, 32'h1); rd(6'h20, v); chk("R9 write 1 clears", v, 0);
        wr(6'h00, 32'hA);
        wr(6'h1C, 32'h1);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_status = 3'd0; rsp_err = 1'b0;
        bus_we = 1'b1; bus_addr = 6'h20; bus_wdata = 32'h1;
        @(negedge clk);
        rsp_valid = 1'b0; bus_we = 1'b0;
        rd(6'h20, v); chk("R9 completion beats clear", v, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule